// File: doc/BRIEF.md
# Three-Phase Asynchronous SRAM Controller

This block lets a slow processor-side bus share one fast clock with the rest of a fully synchronous design. A free-running divide-by-three phase counter raises a clock-enable in one fast cycle out of every three. Each processor cycle is therefore three fast cycles long, and the block maps it onto one access to an asynchronous static RAM. With a 75 MHz fast clock, for example, the processor side runs at an effective 25 MHz.

The processor presents an address, write data, a byte mask and a read or write request. The block samples these on the enable edge. For the next three fast cycles it drives the address, byte enables, chip select, output enable and outgoing data to the memory, all held steady. The write strobe pulses only in the middle cycle of that window, so address, data and byte enables are settled before it falls and still unchanged after it rises. On a read the memory drives the incoming half of the split data bus. The block samples that word at the closing enable edge and returns it to the processor side.

No second clock and no gated clock are used. Every flip-flop runs on the fast clock, and processor-side state moves only when the enable is high.

Top module: `sram3ph_ctrl`

## Requirements
- R1: `cpu_en` is high in exactly one fast cycle out of three. After reset is released it is low for two fast cycles, then high in the third, and the pattern repeats without end.
- R2: Request inputs are sampled only at a clock edge where `cpu_en` is high. The values that drive the memory (`sram_addr`, `sram_dout`, `sram_be_n`, `sram_ce_n`, `sram_oe_n`, `sram_dout_en`) change only at that edge. They stay constant through the three fast cycles that follow, whatever the inputs do in between.
- R3: `sram_we_n` is low only in the second of the three fast cycles of a write access, for exactly one fast cycle. It is high at all other times.
- R4: A write access drives `sram_ce_n`=0, `sram_oe_n`=1, `sram_dout_en`=1 and `sram_dout` = the sampled write data. It drives `sram_be_n` as the bitwise inverse of the sampled mask, where mask bit i = 1 selects byte lane i (data bits 8i+7..8i). Only the selected lanes of the memory word change.
- R5: A read access drives `sram_ce_n`=0, `sram_oe_n`=0, `sram_be_n` = inverted mask and `sram_dout_en`=0. The whole `sram_din` word is sampled at the clock edge that closes the access. That word appears on `cpu_rdata` from the following fast cycle and holds until the next read completes.
- R6: In a processor cycle with neither request, `sram_ce_n`, `sram_oe_n` and every bit of `sram_be_n` are high, `sram_dout_en` is 0 and `sram_we_n` does not pulse. `sram_addr`, `sram_dout` and `cpu_rdata` keep their previous values.
- R7: If read and write are requested together, the cycle is a write. The read is ignored, and `cpu_rdata` is left unchanged.
- R8: While synchronous reset is high, and in the first cycle after it: `cpu_en`=0, `sram_ce_n`=1, `sram_oe_n`=1, `sram_we_n`=1, `sram_be_n` all ones, `sram_dout_en`=0, and `cpu_rdata`, `sram_addr` and `sram_dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single fast clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_en | output | 1 | Processor-side clock enable, one cycle in three |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_mask | input | DATA_W/8 | Byte mask, bit i selects lane i |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request, wins over a read |
| cpu_rdata | output | DATA_W | Captured read word |
| sram_addr | output | ADDR_W | Memory address |
| sram_dout | output | DATA_W | Outgoing data half of the split bus |
| sram_dout_en | output | 1 | Bus drive enable for the outgoing data |
| sram_din | input | DATA_W | Incoming data half of the split bus |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | DATA_W/8 | Byte enables, active low |

## Verification
The bench builds the block with ADDR_W=12 and DATA_W=32. The four byte lanes let sparse masks such as 0101 and 1010 show that each lane is gated on its own. The bench attaches a behavioural memory that commits data on the rising edge of the write strobe. A strobe that leaves its window, or byte enables that are wrong, therefore show up as a wrong word on a later read. The top address bit is set in directed cases so that the full address path is observed.

// File: rtl/sram3ph_pkg.sv
package sram3ph_pkg;

    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_t;

endpackage

// File: rtl/sram3ph_phase.sv
module sram3ph_phase
    import sram3ph_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase_o,
    output logic   cpu_en_o
);

    phase_t phase_d;
    phase_t phase_q;

    always_comb begin
        unique case (phase_q)
            PH0:     phase_d = PH1;
            PH1:     phase_d = PH2;
            default: phase_d = PH0;
        endcase
        if (rst) begin
            phase_d = PH0;
        end
    end

    always_ff @(posedge clk) begin
        phase_q <= phase_d;
    end

    assign phase_o  = phase_q;
    assign cpu_en_o = (phase_q == PH2);

endmodule

// File: rtl/sram3ph_bus.sv
module sram3ph_bus
    import sram3ph_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_en,
    input  phase_t                  phase,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic [DATA_W/8-1:0]     cpu_mask,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    output op_t                     op_o,
    output logic [ADDR_W-1:0]       sram_addr,
    output logic [DATA_W-1:0]       sram_dout,
    output logic                    sram_dout_en,
    output logic                    sram_ce_n,
    output logic                    sram_oe_n,
    output logic                    sram_we_n,
    output logic [DATA_W/8-1:0]     sram_be_n
);

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        op_t               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be_n;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dout_en;
    } bus_state_t;

    bus_state_t st_d;
    bus_state_t st_q;

    always_comb begin
        st_d = st_q;
        // strobe decoded one cycle early so it is low during the middle phase only
        st_d.we_n = !((phase == PH0) && (st_q.op == OP_WR));
        if (cpu_en) begin
            if (cpu_wr) begin
                st_d.op      = OP_WR;
                st_d.addr    = cpu_addr;
                st_d.wdata   = cpu_wdata;
                st_d.be_n    = ~cpu_mask;
                st_d.ce_n    = 1'b0;
                st_d.oe_n    = 1'b1;
                st_d.dout_en = 1'b1;
            end else if (cpu_rd) begin
                st_d.op      = OP_RD;
                st_d.addr    = cpu_addr;
                st_d.be_n    = ~cpu_mask;
                st_d.ce_n    = 1'b0;
                st_d.oe_n    = 1'b0;
                st_d.dout_en = 1'b0;
            end else begin
                st_d.op      = OP_IDLE;
                st_d.be_n    = '1;
                st_d.ce_n    = 1'b1;
                st_d.oe_n    = 1'b1;
                st_d.dout_en = 1'b0;
            end
        end
        if (rst) begin
            st_d.op      = OP_IDLE;
            st_d.addr    = '0;
            st_d.wdata   = '0;
            st_d.be_n    = '1;
            st_d.ce_n    = 1'b1;
            st_d.oe_n    = 1'b1;
            st_d.we_n    = 1'b1;
            st_d.dout_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign op_o         = st_q.op;
    assign sram_addr    = st_q.addr;
    assign sram_dout    = st_q.wdata;
    assign sram_dout_en = st_q.dout_en;
    assign sram_ce_n    = st_q.ce_n;
    assign sram_oe_n    = st_q.oe_n;
    assign sram_we_n    = st_q.we_n;
    assign sram_be_n    = st_q.be_n;

endmodule

// File: rtl/sram3ph_rdcap.sv
module sram3ph_rdcap
    import sram3ph_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_en,
    input  op_t               op,
    input  logic [DATA_W-1:0] sram_din,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (cpu_en && (op == OP_RD)) begin
            rdata_d = sram_din;
        end
        if (rst) begin
            rdata_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/sram3ph_ctrl.sv
module sram3ph_ctrl
    import sram3ph_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    output logic                cpu_en,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [DATA_W/8-1:0] cpu_mask,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [DATA_W-1:0]   sram_dout,
    output logic                sram_dout_en,
    input  logic [DATA_W-1:0]   sram_din,
    output logic                sram_ce_n,
    output logic                sram_oe_n,
    output logic                sram_we_n,
    output logic [DATA_W/8-1:0] sram_be_n
);

    phase_t phase;
    op_t    op;

    sram3ph_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .phase_o  (phase),
        .cpu_en_o (cpu_en)
    );

    sram3ph_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk          (clk),
        .rst          (rst),
        .cpu_en       (cpu_en),
        .phase        (phase),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_mask     (cpu_mask),
        .cpu_rd       (cpu_rd),
        .cpu_wr       (cpu_wr),
        .op_o         (op),
        .sram_addr    (sram_addr),
        .sram_dout    (sram_dout),
        .sram_dout_en (sram_dout_en),
        .sram_ce_n    (sram_ce_n),
        .sram_oe_n    (sram_oe_n),
        .sram_we_n    (sram_we_n),
        .sram_be_n    (sram_be_n)
    );

    sram3ph_rdcap #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk      (clk),
        .rst      (rst),
        .cpu_en   (cpu_en),
        .op       (op),
        .sram_din (sram_din),
        .rdata_o  (cpu_rdata)
    );

endmodule

// File: rtl/sram3ph_chk.sv
module sram3ph_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                cpu_en,
    input logic [ADDR_W-1:0]   sram_addr,
    input logic [DATA_W-1:0]   sram_dout,
    input logic                sram_dout_en,
    input logic                sram_ce_n,
    input logic                sram_oe_n,
    input logic                sram_we_n,
    input logic [DATA_W/8-1:0] sram_be_n
);

    logic [1:0] ck_ph;

    always_ff @(posedge clk) begin
        if (rst || ck_ph == 2'd2) begin
            ck_ph <= 2'd0;
        end else begin
            ck_ph <= ck_ph + 2'd1;
        end
    end

    AST_EN_PHASE: assert property (@(posedge clk) disable iff (rst)
        cpu_en == (ck_ph == 2'd2)); // R1

    AST_WINDOW_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ck_ph != 2'd0) |-> ($stable(sram_addr) && $stable(sram_dout) &&
                             $stable(sram_be_n) && $stable(sram_ce_n) &&
                             $stable(sram_oe_n) && $stable(sram_dout_en))); // R2

    AST_WE_MIDDLE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (ck_ph == 2'd1)); // R3

    AST_WE_CTRL: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dout_en)); // R4

    AST_RD_NODRIVE: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && !sram_dout_en)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        sram_ce_n |-> (sram_we_n && sram_oe_n && (&sram_be_n) && !sram_dout_en)); // R6

endmodule

bind sram3ph_ctrl sram3ph_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_en       (cpu_en),
    .sram_addr    (sram_addr),
    .sram_dout    (sram_dout),
    .sram_dout_en (sram_dout_en),
    .sram_ce_n    (sram_ce_n),
    .sram_oe_n    (sram_oe_n),
    .sram_we_n    (sram_we_n),
    .sram_be_n    (sram_be_n)
);

// File: tb/sram3ph_ctrl_tb.sv
module sram3ph_ctrl_tb;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_en;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [BW-1:0] cpu_mask = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dout;
    logic          sram_dout_en;
    logic [DW-1:0] sram_din;
    logic          sram_ce_n;
    logic          sram_oe_n;
    logic          sram_we_n;
    logic [BW-1:0] sram_be_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    sram3ph_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .cpu_en(cpu_en),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_mask(cpu_mask),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_dout_en(sram_dout_en),
        .sram_din(sram_din), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_be_n(sram_be_n)
    );

    // behavioural memory: commits on the rising edge of the write strobe
    logic [DW-1:0] mem  [16];
    logic [DW-1:0] refm [16];

    assign sram_din = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr[3:0]] : 32'hDEAD_BEEF;

    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0) begin
            for (int b = 0; b < BW; b++) begin
                if (!sram_be_n[b]) mem[sram_addr[3:0]][8*b +: 8] <= sram_dout[8*b +: 8];
            end
        end
    end

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [BW-1:0] m);
        logic [DW-1:0] r = old;
        for (int b = 0; b < BW; b++) begin
            if (m[b]) r[8*b +: 8] = nw[8*b +: 8];
        end
        return r;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    logic [AW-1:0] exp_addr  = '0;
    logic [DW-1:0] exp_wdata = '0;
    logic [DW-1:0] exp_rdata = '0;

    task automatic do_cycle(bit rd, bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] m);
        bit is_wr = wr;
        bit is_rd = rd && !wr;
        string tag;
        logic [BW-1:0] exp_be;
        while (cpu_en !== 1'b1) @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; cpu_mask = m;
        tag = is_wr ? (rd ? "R7" : "R4") : (is_rd ? "R5" : "R6");
        if (is_wr || is_rd) exp_addr = a;
        if (is_wr) exp_wdata = d;
        exp_be = (is_wr || is_rd) ? ~m : '1;
        // phase 0: scramble inputs, they must not matter (R2)
        @(negedge clk);
        cpu_rd = $urandom; cpu_wr = $urandom; cpu_addr = $urandom;
        cpu_wdata = $urandom; cpu_mask = $urandom;
        chk("R1", "cpu_en ph0", cpu_en, 0);
        chk("R5", "cpu_rdata", cpu_rdata, exp_rdata);
        for (int p = 0; p < 3; p++) begin
            if (p > 0) @(negedge clk);
            chk(p == 0 ? tag : "R2", "addr", sram_addr, exp_addr);
            chk(p == 0 ? tag : "R2", "dout", sram_dout, exp_wdata);
            chk(p == 0 ? tag : "R2", "be_n", sram_be_n, exp_be);
            chk(p == 0 ? tag : "R2", "ce_n", sram_ce_n, !(is_wr || is_rd));
            chk(p == 0 ? tag : "R2", "oe_n", sram_oe_n, !is_rd);
            chk(p == 0 ? tag : "R2", "dout_en", sram_dout_en, is_wr);
            chk("R3", "we_n", sram_we_n, !(is_wr && p == 1));
        end
        chk("R1", "cpu_en ph2", cpu_en, 1);
        cpu_rd = 0; cpu_wr = 0;
        if (is_wr) refm[a[3:0]] = merge(refm[a[3:0]], d, m);
        if (is_rd) exp_rdata = refm[a[3:0]];
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            mem[i]  = (i * 32'h0101_0101) ^ 32'hA500_0000;
            refm[i] = (i * 32'h0101_0101) ^ 32'hA500_0000;
        end
        repeat (3) @(negedge clk);
        // R8: reset values
        chk("R8", "cpu_en", cpu_en, 0);
        chk("R8", "ce_n", sram_ce_n, 1);
        chk("R8", "oe_n", sram_oe_n, 1);
        chk("R8", "we_n", sram_we_n, 1);
        chk("R8", "be_n", sram_be_n, {BW{1'b1}});
        chk("R8", "dout_en", sram_dout_en, 0);
        chk("R8", "rdata", cpu_rdata, 0);
        chk("R8", "addr", sram_addr, 0);
        rst = 1'b0;
        chk("R8", "cpu_en first", cpu_en, 0);
        @(negedge clk);
        chk("R1", "cpu_en second", cpu_en, 0);
        @(negedge clk);
        chk("R1", "cpu_en third", cpu_en, 1);

        // directed cases
        do_cycle(0, 1, 12'h003, 32'h1122_3344, 4'b1111);
        do_cycle(1, 0, 12'h003, 32'h0, 4'b1111);
        do_cycle(0, 0, 12'h7A5, 32'hFFFF_FFFF, 4'b1111);   // idle, R6 hold
        do_cycle(0, 1, 12'hFF5, 32'hCAFE_F00D, 4'b0101);   // top address bit, sparse mask
        do_cycle(1, 0, 12'hFF5, 32'h0, 4'b0011);
        do_cycle(0, 1, 12'h805, 32'h5566_7788, 4'b1010);
        do_cycle(1, 1, 12'h006, 32'h99AA_BBCC, 4'b1111);   // R7 both
        do_cycle(1, 0, 12'h005, 32'h0, 4'b0001);
        do_cycle(1, 0, 12'h006, 32'h0, 4'b1111);
        do_cycle(0, 0, 12'h000, 32'h0, 4'b0000);
        do_cycle(0, 0, 12'h111, 32'h0, 4'b1111);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            bit rd = (k < 5) || (k == 9);
            bit wr = (k >= 5) && (k < 8) || (k == 9);
            do_cycle(rd, wr, AW'($urandom), DW'($urandom), BW'($urandom));
        end
        do_cycle(0, 0, 12'h0, 32'h0, 4'b0);
        // sweep every word back once
        for (int i = 0; i < 16; i++) do_cycle(1, 0, AW'(i), 32'h0, 4'b1111);
        do_cycle(0, 0, 12'h0, 32'h0, 4'b0);
        summary();
    end

endmodule